// File: doc/BRIEF.md
# Override-Gated Configuration Output Selector

This block drives six open-drain configuration pins from two sources. Five of them, the lanes, carry either the low five bits of a stored 6-bit configuration word or five external inputs, depending on a select input. The sixth pin, the hold pin, carries the top bit of the stored word. It follows that bit while the select is low. When the select rises, it freezes at whatever value it was showing at that moment.

An active-low force input can pull all six pins low, but only while the select is low. While the select is high, the force input has no effect. The stored word comes from outside the block, as a plain 6-bit bus.

The select and force inputs may be asynchronous. Each goes through a two-flop synchroniser. A three-state machine then decides what drives the pins:

- TRACK: select low, force released. The pins show the stored word.
- FORCE: select low, force asserted. All six pins are pulled low.
- PASS: select high. The lanes show the external inputs and the hold pin keeps its frozen value.

The state transitions are:

- TRACK to FORCE when force is asserted, and FORCE to TRACK when it is released.
- TRACK or FORCE to PASS on the synchronised rise of the select. This is the capture event.
- PASS to TRACK, or PASS to FORCE, on the fall of the select, chosen by the force level at that time.

The pin values are registered from the next state.

Top module: `cfg_mux_hold`

## Requirements
- R1: In TRACK, lane i takes bit i of `cfg_bits` (bits 0 to 4) and the hold pin takes bit 5. A change of `cfg_bits` reaches the pins on the next rising clock edge.
- R2: In PASS, lane i takes `ext_in[i]`. A change of `ext_in` reaches the pins on the next rising edge.
- R3: While the select stays high, the hold pin keeps the value it showed on entry to PASS. Changes of `cfg_bits` do not alter it.
- R4: In FORCE, all six pin values are 0, whatever `cfg_bits` holds.
- R5: In PASS, the level of `ovr_n_in` has no effect on any pin.
- R6: When the select rises while the pins are forced, the hold pin freezes at value 0.
- R7: The open-drain encoding is as follows. A pull-down output of 1 pulls the pin low, which is pin value 0. A pull-down output of 0 releases the pin, which is pin value 1.
- R8: A change of `sel_in` or `ovr_n_in` shows on the pins at the third rising edge after it and not before.
- R9: During reset, the hold value is 0 and all lane values are 0, so every pull-down output is 1. The select is taken as low and the force as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bits | input | 6 | Stored configuration word; bits 0 to 4 feed the lanes, bit 5 feeds the hold pin |
| ext_in | input | 5 | External lane inputs |
| sel_in | input | 1 | Select, asynchronous: 1 routes the external inputs and freezes the hold pin |
| ovr_n_in | input | 1 | Force, asynchronous, active low |
| mux_pd | output | 5 | Pull-down enables of the five lanes |
| hold_pd | output | 1 | Pull-down enable of the hold pin |

## Verification
Random words on `cfg_bits` and `ext_in` are driven every cycle. Meanwhile select and force toggle rarely, so the bench passes through every state and every transition. It compares each pin against its own model of the synchronisers and the state choice.

Several directed cases target single behaviours:

- A complementary pair on `cfg_bits` and `ext_in` separates the two lane sources. It also shows whether the latency is exactly three edges.
- Changing bit 5 of the stored word after entering PASS shows whether the hold pin is truly frozen.
- Raising the select while forced separates freezing the displayed value from freezing the stored bit.
- Toggling force during PASS shows whether the force is gated by the select.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
    typedef enum logic [1:0] {
        CMX_TRACK = 2'd0,
        CMX_FORCE = 2'd1,
        CMX_PASS  = 2'd2
    } cmx_state_e;
endpackage

// File: rtl/cmx_sync.sv
module cmx_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmx_fsm.sv
module cmx_fsm
    import cmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_s,
    input  logic       ovr_n_s,
    output cmx_state_e st_nxt,
    output cmx_state_e st_cur
);
    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_cur <= CMX_TRACK;
        else        st_cur <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st_cur;
        unique case (st_cur)
            CMX_TRACK: begin
                if (sel_s)         st_nxt = CMX_PASS;   // capture event
                else if (!ovr_n_s) st_nxt = CMX_FORCE;
            end
            CMX_FORCE: begin
                if (sel_s)         st_nxt = CMX_PASS;   // capture event
                else if (ovr_n_s)  st_nxt = CMX_TRACK;
            end
            CMX_PASS: begin
                if (!sel_s)        st_nxt = ovr_n_s ? CMX_TRACK : CMX_FORCE;
            end
            default:               st_nxt = CMX_TRACK;
        endcase
    end

    // R3: a high select always lands in PASS
    p_sel_enters_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (st_cur == CMX_PASS));
    // R4: low select with force asserted lands in FORCE
    p_force_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && !ovr_n_s) |=> (st_cur == CMX_FORCE));
endmodule

// File: rtl/cmx_drive.sv
module cmx_drive
    import cmx_pkg::*;
#(
    parameter int N_MUX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmx_state_e       st_nxt,
    input  logic [N_MUX:0]   cfg_bits,
    input  logic [N_MUX-1:0] ext_in,
    input  logic             sel_s,
    input  logic             ovr_n_s,
    output logic [N_MUX-1:0] mux_pd,
    output logic             hold_pd
);
    logic [N_MUX-1:0] mux_val;
    logic             hold_val;

    // pin values, registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_val  <= '0;
            hold_val <= 1'b0;
        end else begin
            unique case (st_nxt)
                CMX_TRACK: begin
                    mux_val  <= cfg_bits[N_MUX-1:0];
                    hold_val <= cfg_bits[N_MUX];
                end
                CMX_FORCE: begin
                    mux_val  <= '0;
                    hold_val <= 1'b0;
                end
                CMX_PASS: begin
                    mux_val  <= ext_in;
                    hold_val <= hold_val;
                end
                default: begin
                    mux_val  <= '0;
                    hold_val <= 1'b0;
                end
            endcase
        end
    end

    // open-drain enables: value 0 pulls the pin low
    for (genvar g = 0; g < N_MUX; g++) begin : g_lane
        assign mux_pd[g] = ~mux_val[g];
    end
    assign hold_pd = ~hold_val;

    p_track_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && ovr_n_s) |=> (mux_pd == ~$past(cfg_bits[N_MUX-1:0]))
                                 && (hold_pd == ~$past(cfg_bits[N_MUX])));
    p_pass_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (mux_pd == ~$past(ext_in)));
    p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> $stable(hold_pd));
    p_force_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && !ovr_n_s) |=> ((&mux_pd) && hold_pd));
endmodule

// File: rtl/cfg_mux_hold.sv
module cfg_mux_hold #(
    parameter int N_MUX       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MUX:0]   cfg_bits,
    input  logic [N_MUX-1:0] ext_in,
    input  logic             sel_in,
    input  logic             ovr_n_in,
    output logic [N_MUX-1:0] mux_pd,
    output logic             hold_pd
);
    localparam int CTL_W = 2;

    logic [CTL_W-1:0]    ctl_s;
    logic                sel_s;
    logic                ovr_n_s;
    cmx_pkg::cmx_state_e st_nxt;
    cmx_pkg::cmx_state_e st_cur;

    // R8/R9: select resets to 0, force resets to released
    cmx_sync #(
        .W      (CTL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sel_in, ovr_n_in}),
        .q    (ctl_s)
    );

    assign sel_s   = ctl_s[1];
    assign ovr_n_s = ctl_s[0];

    cmx_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_s  (sel_s),
        .ovr_n_s(ovr_n_s),
        .st_nxt (st_nxt),
        .st_cur (st_cur)
    );

    cmx_drive #(.N_MUX(N_MUX)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_nxt  (st_nxt),
        .cfg_bits(cfg_bits),
        .ext_in  (ext_in),
        .sel_s   (sel_s),
        .ovr_n_s (ovr_n_s),
        .mux_pd  (mux_pd),
        .hold_pd (hold_pd)
    );
endmodule

// File: tb/cfg_mux_hold_bench.sv
module cfg_mux_hold_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_bits = '0;
    logic [4:0] ext_in = '0;
    logic       sel_in = 1'b0;
    logic       ovr_n_in = 1'b1;
    logic [4:0] mux_pd;
    logic       hold_pd;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_mux_hold u_cfg_mux_hold (
        .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .ext_in(ext_in),
        .sel_in(sel_in), .ovr_n_in(ovr_n_in), .mux_pd(mux_pd), .hold_pd(hold_pd)
    );

    // reference model: two-stage sync, then a registered pin value
    logic       m_s1, m_s2, m_o1, m_o2;
    logic [4:0] m_mux;
    logic       m_hold;
    int         m_mode;   // 0 track, 1 force, 2 pass, 3 pass with force low

    function automatic logic [4:0] od_lanes(logic [4:0] v);
        return ~v;   // R7
    endfunction
    function automatic logic od_pin(logic v);
        return ~v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_o1 <= 1'b1; m_o2 <= 1'b1;
            m_mux <= '0; m_hold <= 1'b0; m_mode <= 0;
        end else begin
            m_s1 <= sel_in;   m_s2 <= m_s1;
            m_o1 <= ovr_n_in; m_o2 <= m_o1;
            if (m_s2) begin
                m_mux  <= ext_in;
                m_mode <= m_o2 ? 2 : 3;
            end else if (!m_o2) begin
                m_mux <= '0; m_hold <= 1'b0; m_mode <= 1;
            end else begin
                m_mux <= cfg_bits[4:0]; m_hold <= cfg_bits[5]; m_mode <= 0;
            end
        end
    end

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_check();
        string lt, ht;
        case (m_mode)
            0: begin lt = "R1 lanes"; ht = "R1 hold"; end
            1: begin lt = "R4 lanes"; ht = "R4 hold"; end
            2: begin lt = "R2 lanes"; ht = "R3 hold"; end
            default: begin lt = "R5 lanes"; ht = "R5 hold"; end
        endcase
        chk(lt, {1'b0, mux_pd}, {1'b0, od_lanes(m_mux)});
        chk(ht, {5'b0, hold_pd}, {5'b0, od_pin(m_hold)});
    endtask

    task automatic tick();
        @(negedge clk);
        model_check();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 reset pull-downs", {hold_pd, mux_pd}, 6'h3F);
        rst_n = 1'b1;
        repeat (3) tick();

        // R7: encoding
        cfg_bits = 6'b010101;
        tick(); tick();
        chk("R7 encoding", {hold_pd, mux_pd}, 6'b101010);

        // R8: latency of select
        cfg_bits = 6'b100011; ext_in = 5'b11100;
        tick();
        sel_in = 1'b1;
        tick(); tick();
        chk("R8 no change after 2 edges", {1'b0, mux_pd}, {1'b0, od_lanes(5'b00011)});
        tick();
        chk("R8 change at 3rd edge", {1'b0, mux_pd}, {1'b0, od_lanes(5'b11100)});

        // R3: hold frozen at 1 while stored bit moves
        cfg_bits = 6'b000000;
        repeat (4) tick();
        chk("R3 hold frozen", {5'b0, hold_pd}, 6'd0);

        // R5: force ignored in PASS
        ovr_n_in = 1'b0; ext_in = 5'b10110;
        repeat (4) tick();
        chk("R5 lanes with force", {1'b0, mux_pd}, {1'b0, od_lanes(5'b10110)});
        chk("R5 hold with force", {5'b0, hold_pd}, 6'd0);

        // R4: select low, force low
        sel_in = 1'b0; cfg_bits = 6'b111111;
        repeat (4) tick();
        chk("R4 all forced", {hold_pd, mux_pd}, 6'h3F);

        // R6: rise while forced freezes 0
        sel_in = 1'b1;
        repeat (4) tick();
        ovr_n_in = 1'b1;
        repeat (4) tick();
        chk("R6 hold frozen at 0", {5'b0, hold_pd}, 6'd1);

        // R1: back to track, one-edge update of the stored word
        sel_in = 1'b0;
        repeat (4) tick();
        cfg_bits = 6'b101001;
        tick();
        chk("R1 next-edge update", {hold_pd, mux_pd}, ~6'b101001);

        // random mix
        for (int i = 0; i < 400; i++) begin
            cfg_bits = 6'($urandom);
            ext_in   = 5'($urandom);
            if ($urandom_range(7) == 0) sel_in = ~sel_in;
            if ($urandom_range(5) == 0) ovr_n_in = ~ovr_n_in;
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule